// File: doc/BRIEF.md
# Three-Button Ordered Press Detector

This block watches three push-button press pulses and recognises the ordered sequence first button, second button, third button. Each input is a single-cycle pulse that upstream logic has already debounced and edge-detected. When the third button completes the sequence, the block enters a hit state. It drives an indicator high for a fixed hold interval, which is about one second at the target clock. After the interval it falls back to waiting for the first button.

A press that breaks the sequence sends the machine back to the start. There is one exception: a press of the first button always counts as the start of a new attempt. The current state is exported as a two-bit code so that a display or a debug path can follow progress. The hold length is the parameter `HOLD_CYCLES`. Its default gives one second at 250 MHz, and a bench overrides it with a small value.

Top module: `seq_press_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state becomes first-wait (`state_o` = 2'd0) and `indicator` is low. The state codes are first-wait 0, second-wait 1, third-wait 2 and hit 3.
- R2: In first-wait, a lone `press_a` pulse moves the state to second-wait at the next edge.
- R3: In second-wait, a lone `press_b` pulse moves the state to third-wait at the next edge.
- R4: In third-wait, a lone `press_c` pulse moves the state to hit at the next edge, and `indicator` goes high at that edge.
- R5: A lone press that does not fit the sequence returns the state to first-wait. These presses are `press_b` or `press_c` in first-wait, `press_c` in second-wait, and `press_b` in third-wait.
- R6: In third-wait, a lone `press_a` moves the state to second-wait.
- R7: In second-wait, a lone `press_a` keeps the state in second-wait.
- R8: In any wait state, a cycle with no press leaves the state unchanged.
- R9: In any wait state, two or more press pulses in the same cycle count as a wrong press, and the state becomes first-wait.
- R10: The hit state, and with it `indicator`, lasts exactly `HOLD_CYCLES` clock cycles. After that the state is first-wait.
- R11: Press pulses that arrive during the hit state have no effect. They neither shorten nor extend the hold, and they do not change the state.
- R12: `indicator` is high exactly when `state_o` is 3.
- R13: A reset applied partway through a sequence or during the hold returns the state to first-wait with `indicator` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| press_a | input | 1 | Single-cycle pulse for the first button of the sequence |
| press_b | input | 1 | Single-cycle pulse for the second button |
| press_c | input | 1 | Single-cycle pulse for the third button |
| indicator | output | 1 | High during the hit hold interval |
| state_o | output | 2 | Current state code (0 first-wait, 1 second-wait, 2 third-wait, 3 hit) |

## Verification
Every state change is due in the cycle right after the edge that samples the press. A press driven before edge k shows on `state_o` after edge k. `indicator` is decoded from the state register, so it moves in the same cycle as the state. The hold ends `HOLD_CYCLES` edges after the edge that entered the hit state. The bench drives inputs on the falling edge and keeps a behavioural model updated for the same rising edge as the design. It compares `state_o` and `indicator` on the following falling edge, so every result is read exactly one edge after its stimulus.

// File: rtl/seqdet_pkg.sv
// Package: shared types for the ordered press detector.
// Assumes: state codes are visible at the top port and must keep these values.
package seqdet_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_A = 2'd0,
        ST_WAIT_B = 2'd1,
        ST_WAIT_C = 2'd2,
        ST_HIT    = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        PK_NONE   = 3'd0,
        PK_FIRST  = 3'd1,
        PK_SECOND = 3'd2,
        PK_THIRD  = 3'd3,
        PK_MULTI  = 3'd4
    } press_kind_t;

endpackage

// File: rtl/seqdet_press_classify.sv
// Module: seqdet_press_classify
// Reduces the three press pulses of one cycle to a single press kind.
// Assumes: pulses are already clean and one cycle wide; more than one pulse
// at once is reported as PK_MULTI.
module seqdet_press_classify
    import seqdet_pkg::*;
#(
    parameter int unsigned N_BUTTONS = 3
) (
    input  logic [N_BUTTONS-1:0] press,
    output press_kind_t          kind
);

    localparam int unsigned CNT_W = $clog2(N_BUTTONS + 1);

    logic [CNT_W-1:0] n_active;

    // Purpose: count the pulses that are high in this cycle.
    always_comb begin
        n_active = '0;
        for (int i = 0; i < N_BUTTONS; i++) begin
            n_active = n_active + CNT_W'(press[i]);
        end
    end

    // Purpose: map the pulse pattern onto a press kind.
    always_comb begin
        if (n_active == '0)      kind = PK_NONE;
        else if (n_active > 1)   kind = PK_MULTI;
        else if (press[0])       kind = PK_FIRST;
        else if (press[1])       kind = PK_SECOND;
        else                     kind = PK_THIRD;
    end

    // a_r9_multi_flag: several pulses in one cycle are always classed as multi
    always_comb begin
        a_r9_multi_flag: assert (!($countones(press) > 1) || kind == PK_MULTI);
    end

endmodule

// File: rtl/seqdet_hold_timer.sv
// Module: seqdet_hold_timer
// Counts the cycles spent in the hit state and flags the last one.
// Assumes: `active` stays high for the whole hold and drops once `done` has
// been seen; the count restarts from zero whenever `active` is low.
module seqdet_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Purpose: advance the hold count while active, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end

    // Purpose: mark the final cycle of the hold.
    assign done = active && (cnt == LAST);

    // a_r10_count_bound: the count never runs past the final hold cycle
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // a_r10_fresh_start: an inactive cycle leaves the count at zero
    a_r10_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt == '0);

endmodule

// File: rtl/seqdet_fsm.sv
// Module: seqdet_fsm
// Sequence state machine: steps through the three waits on correct presses,
// applies the restart rules on wrong ones, and holds the hit state until the
// timer reports the end of the hold.
// Assumes: `kind` is already classified and `hold_done` comes from a timer
// that is running only while the state is ST_HIT.
module seqdet_fsm
    import seqdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  press_kind_t kind,
    input  logic        hold_done,
    output seq_state_t  state,
    output logic        hit
);

    seq_state_t state_nx;

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_A;
        else        state <= state_nx;
    end

    // Purpose: next-state rules for every state and press kind.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_A: begin
                if (kind == PK_FIRST)     state_nx = ST_WAIT_B;
                else if (kind != PK_NONE) state_nx = ST_WAIT_A;
            end
            ST_WAIT_B: begin
                if (kind == PK_SECOND)     state_nx = ST_WAIT_C;
                else if (kind == PK_FIRST) state_nx = ST_WAIT_B;
                else if (kind != PK_NONE)  state_nx = ST_WAIT_A;
            end
            ST_WAIT_C: begin
                if (kind == PK_THIRD)      state_nx = ST_HIT;
                else if (kind == PK_FIRST) state_nx = ST_WAIT_B;
                else if (kind != PK_NONE)  state_nx = ST_WAIT_A;
            end
            ST_HIT: begin
                if (hold_done) state_nx = ST_WAIT_A;
            end
            default: state_nx = ST_WAIT_A;
        endcase
    end

    // Purpose: Moore output, high for the whole hit state.
    assign hit = (state == ST_HIT);

    // a_r4_enter_hit: third press in third-wait reaches the hit state
    a_r4_enter_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_C && kind == PK_THIRD) |=> state == ST_HIT);

    // a_r6_restart: first press in third-wait starts a new attempt
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_C && kind == PK_FIRST) |=> state == ST_WAIT_B);

    // a_r8_idle_hold: no press leaves a wait state alone
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HIT && kind == PK_NONE) |=> $stable(state));

    // a_r9_multi_wrong: simultaneous presses send a wait state back to the start
    a_r9_multi_wrong: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HIT && kind == PK_MULTI) |=> state == ST_WAIT_A);

    // a_r11_hold_ignores: presses cannot leave the hit state before the timer
    a_r11_hold_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIT && !hold_done) |=> state == ST_HIT);

endmodule

// File: rtl/seq_press_detect.sv
// Module: seq_press_detect (top)
// Ordered three-button press detector with a timed indicator.
// Assumes: the press inputs are clean single-cycle pulses in the clk domain;
// HOLD_CYCLES is the hold length in clock cycles (default: 1 s at 250 MHz).
module seq_press_detect
    import seqdet_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       press_a,
    input  logic       press_b,
    input  logic       press_c,
    output logic       indicator,
    output logic [1:0] state_o
);

    localparam int unsigned N_BUTTONS = 3;

    press_kind_t kind;
    seq_state_t  state;
    logic        hold_done;
    logic        hit;

    seqdet_press_classify #(.N_BUTTONS(N_BUTTONS)) u_classify (
        .press ({press_c, press_b, press_a}),
        .kind  (kind)
    );

    seqdet_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (hit),
        .done   (hold_done)
    );

    seqdet_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .hold_done (hold_done),
        .state     (state),
        .hit       (hit)
    );

    // Purpose: export the indicator and the state code.
    assign indicator = hit;
    assign state_o   = state;

    // a_r4_rise_source: the indicator only rises out of third-wait
    a_r4_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(indicator) |-> $past(state_o) == 2'd2);

    // a_r10_fall_target: when the indicator drops, the state is first-wait
    a_r10_fall_target: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(indicator) |-> state_o == 2'd0);

endmodule

// File: tb/tb_seq_press_detect.sv
// Bench for seq_press_detect: a behavioural model is advanced for every edge
// and compared with state_o and indicator on each falling edge.
module tb_seq_press_detect;

    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       press_a = 1'b0;
    logic       press_b = 1'b0;
    logic       press_c = 1'b0;
    logic       indicator;
    logic [1:0] state_o;

    int checks = 0;
    int fails  = 0;
    int m_state = 0;
    int m_cnt   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seq_press_detect #(.HOLD_CYCLES(HOLD)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_a   (press_a),
        .press_b   (press_b),
        .press_c   (press_c),
        .indicator (indicator),
        .state_o   (state_o)
    );

    // Model update for one rising edge, from the requirements.
    task automatic model_edge(input bit r, input bit a, input bit b, input bit c);
        int n;
        n = int'(a) + int'(b) + int'(c);
        if (!r) begin
            m_state = 0; m_cnt = 0;
        end else if (m_state == 3) begin
            if (m_cnt == HOLD - 1) begin m_state = 0; m_cnt = 0; end
            else m_cnt++;
        end else if (n == 1) begin
            case (m_state)
                0: m_state = a ? 1 : 0;
                1: m_state = a ? 1 : (b ? 2 : 0);
                default: begin
                    if (c) begin m_state = 3; m_cnt = 0; end
                    else m_state = a ? 1 : 0;
                end
            endcase
        end else if (n > 1) begin
            m_state = 0;
        end
    endtask

    // One cycle: drive at the falling edge, then compare one edge later.
    task automatic step(input string tag, input bit r, input bit a, input bit b, input bit c);
        rst_n = r; press_a = a; press_b = b; press_c = c;
        model_edge(r, a, b, c);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(state_o) != m_state) begin
            fails++;
            $display("FAIL %s: state_o=%0d expected %0d", tag, state_o, m_state);
        end
        checks++;
        if (indicator != (m_state == 3)) begin
            fails++;
            $display("FAIL %s/R12: indicator=%0b expected %0b", tag, indicator, (m_state == 3));
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        step("R1", 0, 0, 0, 0);
        step("R1", 0, 1, 1, 1);
        step("R1", 0, 0, 0, 0);
        idle("R8", 2);
        // correct sequence, presses during hold, full hold
        step("R2", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1);
        step("R11", 1, 1, 0, 0);
        step("R11", 1, 0, 0, 1);
        step("R11", 1, 1, 1, 1);
        idle("R10", HOLD);
        // wrong presses
        step("R5", 1, 0, 1, 0);
        step("R5", 1, 0, 0, 1);
        step("R2", 1, 1, 0, 0);
        step("R5", 1, 0, 0, 1);
        step("R2", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R5", 1, 0, 1, 0);
        // partial then restart
        step("R2", 1, 1, 0, 0);
        idle("R8", 3);
        step("R3", 1, 0, 1, 0);
        idle("R8", 2);
        step("R6", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1);
        idle("R10", HOLD + 1);
        // double first press
        step("R2", 1, 1, 0, 0);
        step("R7", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1);
        idle("R10", HOLD + 1);
        // simultaneous presses
        step("R2", 1, 1, 0, 0);
        step("R9", 1, 1, 1, 0);
        step("R9", 1, 1, 1, 0);
        step("R2", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R9", 1, 0, 1, 1);
        // reset mid-sequence and mid-hold
        step("R2", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R13", 0, 0, 0, 1);
        step("R13", 1, 0, 0, 1);
        step("R2", 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1);
        idle("R10", 2);
        step("R13", 0, 0, 0, 0);
        idle("R13", 2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule